// File: doc/BRIEF.md
# NAND ECC control and status unit

This block is the register-mapped front end of a Reed-Solomon ECC engine for NAND page data. A CPU reaches it over a simple write-strobe bus with combinational read data. Through that bus it sees a control register, nine byte-wide parity registers, a status register and four error-report registers. The symbol arithmetic sits in an external codec. This unit counts the data bytes of a 512-byte chunk and starts the codec with a one-cycle start pulse. It waits for the codec's done strobe and then records the results.

When encoding, the codec returns nine parity bytes, which land in the parity registers for software to read out. When decoding, software first loads the parity bytes it read from the spare area, then raises a parity-ready control bit. The codec is started only once that bit is set and the whole chunk has been counted. On completion the unit latches an error count, an uncorrectable flag and the index/mask reports that the count declares valid.

Top module: `nand_ecc_csr`

## Requirements
- R1: After reset every register reads zero and `codec_start` is low.
- R2: Address 0 is the control register, with bit 0 enable, bit 1 engine reset, bit 2 RS mode and bit 3 encode (1) or decode (0). Bit 4 is parity-ready. Bits 0, 2, 3 and 4 read back as written, bit 1 always reads 0, and `codec_rs` follows bit 2. `codec_encode` gives the direction latched for the current pass.
- R3: Only data bytes strobed while enable is 1 are counted. `codec_start` is high for exactly one cycle, in the cycle after the edge that takes the 512th byte of an encode pass. Any further bytes start nothing.
- R4: A `codec_done` strobe during an encode pass stores `codec_par_in` byte k at address 2+k, in bits 7:0. It also sets status bit 0 (encode finished).
- R5: In a decode pass the codec starts only after both the 512th byte and control bit 4 are seen. It starts one cycle after the later of the two has been registered. `codec_par_out` carries the nine parity registers, with byte k in bits 8k+7:8k.
- R6: A `codec_done` strobe during a decode pass sets status bit 1 (decode finished). It sets bit 3 to `codec_uncor`, loads bits 6:4 with `codec_err_cnt`, and sets bit 2 when the count is nonzero or the pass is uncorrectable.
- R7: The report registers sit at addresses 11 to 14, each reading the mask in bits 8:0 and the symbol index in bits 25:16. Report k is loaded from its codec slice, with the mask in the low 9 bits and the index above it, only when k is below the reported count; otherwise it reads zero.
- R8: A write to address 1 ANDs the status bits with the written byte, so writing zero clears every flag and the count.
- R9: When a status write and a hardware flag set fall in the same cycle, the hardware-set values win.
- R10: A control write with bit 1 set clears the parity and report registers, the byte count and the pass state at that edge. It leaves the status untouched.
- R11: Clearing enable after a pass keeps the parity, report and status contents.
- R12: A `codec_done` strobe when no pass is in flight changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| byte_vld | input | 1 | One chunk data byte passes this cycle |
| codec_start | output | 1 | One-cycle start pulse to the codec |
| codec_encode | output | 1 | Direction of the current pass, 1 for encode |
| codec_rs | output | 1 | RS mode select |
| codec_par_out | output | 72 | Parity bytes handed to the codec for decode |
| codec_done | input | 1 | Codec finished strobe |
| codec_par_in | input | 72 | Parity produced by an encode |
| codec_err_cnt | input | 3 | Number of errors found by a decode |
| codec_uncor | input | 1 | Decode found the chunk uncorrectable |
| codec_reports | input | 76 | Four 19-bit reports, mask low, index high |

## Verification
The assertions assume the codec behaves: it never reports more errors than there are report registers, and it raises `codec_done` only after the start pulse. They also assume software touches the status register only through the bus. The stimulus keeps error counts in range and delivers every normal done strobe only after the start pulse has been seen. The one deliberately stray strobe comes after the pass has finished, and it reports a count of at most four. A behavioural model in the bench predicts the start pulse from bus writes and byte strobes alone, and compares it on every clock.

// File: rtl/necc_pkg.sv
package necc_pkg;
  typedef enum logic [2:0] {
    PS_FILL  = 3'd0,
    PS_WAITP = 3'd1,
    PS_KICK  = 3'd2,
    PS_BUSY  = 3'd3,
    PS_DONE  = 3'd4
  } pass_e;

  // control bit positions (software contract)
  localparam int CB_EN   = 0;
  localparam int CB_RST  = 1;
  localparam int CB_RS   = 2;
  localparam int CB_ENC  = 3;
  localparam int CB_PRDY = 4;

  // status bit positions
  localparam int SB_ENCF = 0;
  localparam int SB_DECF = 1;
  localparam int SB_ERR  = 2;
  localparam int SB_UNC  = 3;
  localparam int SB_CNT  = 4;
endpackage

// File: rtl/necc_pass_fsm.sv
module necc_pass_fsm
  import necc_pkg::*;
#(
  parameter int CHUNK_BYTES = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic enc_sel,
  input  logic prdy,
  input  logic byte_vld,
  input  logic codec_done,
  output logic codec_start,
  output logic pass_enc,
  output logic pass_fin
);
  localparam int BCW = $clog2(CHUNK_BYTES);
  localparam logic [BCW-1:0] LAST = BCW'(CHUNK_BYTES - 1);

  pass_e          st_q, st_d;
  logic [BCW-1:0] bc_q, bc_d;
  logic           enc_q, enc_d;

  always_comb begin
    st_d  = st_q;
    bc_d  = bc_q;
    enc_d = enc_q;
    if (clr) begin
      st_d = PS_FILL;
      bc_d = '0;
    end else begin
      case (st_q)
        PS_FILL: begin
          if (en && byte_vld) begin
            if (bc_q == LAST) begin
              enc_d = enc_sel;
              st_d  = enc_sel ? PS_KICK : PS_WAITP;
            end else begin
              bc_d = bc_q + BCW'(1);
            end
          end
        end
        PS_WAITP: if (en && prdy) st_d = PS_KICK;
        PS_KICK:  st_d = PS_BUSY;
        PS_BUSY:  if (codec_done) st_d = PS_DONE;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_FILL;
      bc_q  <= '0;
      enc_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      bc_q  <= bc_d;
      enc_q <= enc_d;
    end
  end

  assign codec_start = (st_q == PS_KICK);
  assign pass_enc    = enc_q;
  assign pass_fin    = (st_q == PS_BUSY) && codec_done;

  // R3
  kick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    codec_start |=> !codec_start);
  // R5
  dec_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(codec_start) && !pass_enc) |-> $past(prdy));
  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != PS_FILL) |=> ($stable(bc_q) || bc_q == '0));
  // R10
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (st_q == PS_FILL && bc_q == '0));
endmodule

// File: rtl/necc_parity_file.sv
module necc_parity_file #(
  parameter int NBYTES = 9,
  parameter int IW     = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [7:0]        wr_byte,
  input  logic              cap_en,
  input  logic [NBYTES*8-1:0] cap_bus,
  output logic [NBYTES*8-1:0] par_bus
);
  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    logic [7:0] b_q, b_d;
    always_comb begin
      b_d = b_q;
      if (clr)                                 b_d = '0;
      else if (cap_en)                         b_d = cap_bus[k*8 +: 8];
      else if (wr_en && wr_idx == IW'(k))      b_d = wr_byte;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) b_q <= '0;
      else        b_q <= b_d;
    end
    assign par_bus[k*8 +: 8] = b_q;
  end

  // R4
  cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !clr) |=> (par_bus == $past(cap_bus)));
endmodule

// File: rtl/necc_report_file.sv
module necc_report_file #(
  parameter int N_REP  = 4,
  parameter int IDX_W  = 10,
  parameter int MASK_W = 9,
  parameter int CNT_W  = 3,
  parameter int RW     = IDX_W + MASK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               cap_en,
  input  logic [CNT_W-1:0]   cnt_in,
  input  logic [N_REP*RW-1:0] rep_in,
  output logic [N_REP*RW-1:0] rep_out
);
  for (genvar k = 0; k < N_REP; k++) begin : g_rep
    logic [RW-1:0] r_q, r_d;
    always_comb begin
      r_d = r_q;
      if (clr)         r_d = '0;
      else if (cap_en) r_d = (cnt_in > CNT_W'(k)) ? rep_in[k*RW +: RW] : '0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= '0;
      else        r_q <= r_d;
    end
    assign rep_out[k*RW +: RW] = r_q;
  end

  // R7
  top_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !clr && cnt_in < CNT_W'(N_REP)) |=> (rep_out[N_REP*RW-1 -: RW] == '0));
endmodule

// File: rtl/nand_ecc_csr.sv
module nand_ecc_csr
  import necc_pkg::*;
#(
  parameter int CHUNK_BYTES = 512,
  parameter int PAR_BYTES   = 9,
  parameter int N_REP       = 4,
  parameter int IDX_W       = 10,
  parameter int MASK_W      = 9,
  parameter int ADDR_W      = 4,
  parameter int CNT_W       = $clog2(N_REP + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [7:0]                    bus_wdata,
  output logic [31:0]                   bus_rdata,
  input  logic                          byte_vld,
  output logic                          codec_start,
  output logic                          codec_encode,
  output logic                          codec_rs,
  output logic [PAR_BYTES*8-1:0]        codec_par_out,
  input  logic                          codec_done,
  input  logic [PAR_BYTES*8-1:0]        codec_par_in,
  input  logic [CNT_W-1:0]              codec_err_cnt,
  input  logic                          codec_uncor,
  input  logic [N_REP*(IDX_W+MASK_W)-1:0] codec_reports
);
  localparam int PAR_BASE = 2;
  localparam int REP_BASE = PAR_BASE + PAR_BYTES;
  localparam int RW       = IDX_W + MASK_W;
  localparam int PIW      = $clog2(PAR_BYTES);
  localparam int SW       = SB_CNT + CNT_W;

  logic [4:0]    ctrl_q, ctrl_d;
  logic [SW-1:0] st_q, st_d;
  logic          ctrl_wr, sts_wr, sw_clr, par_wr;
  logic [PIW-1:0] par_idx;
  logic          pass_enc, pass_fin;
  logic [N_REP*RW-1:0] rep_bus;

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(0));
  assign sts_wr  = bus_wr && (bus_addr == ADDR_W'(1));
  assign sw_clr  = ctrl_wr && bus_wdata[CB_RST];
  assign par_wr  = bus_wr && (int'(bus_addr) >= PAR_BASE) && (int'(bus_addr) < REP_BASE);
  assign par_idx = PIW'(int'(bus_addr) - PAR_BASE);

  // control register: reset bit is a strobe, never stored
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d         = bus_wdata[4:0];
      ctrl_d[CB_RST] = 1'b0;
    end
  end

  // status: software AND-clear, hardware set has the last word
  always_comb begin
    st_d = sts_wr ? (st_q & bus_wdata[SW-1:0]) : st_q;
    if (pass_fin && pass_enc) st_d[SB_ENCF] = 1'b1;
    if (pass_fin && !pass_enc) begin
      st_d[SB_DECF]          = 1'b1;
      st_d[SB_ERR]           = (codec_err_cnt != '0) || codec_uncor;
      st_d[SB_UNC]           = codec_uncor;
      st_d[SB_CNT +: CNT_W]  = codec_err_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      st_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      st_q   <= st_d;
    end
  end

  necc_pass_fsm #(.CHUNK_BYTES(CHUNK_BYTES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .clr(sw_clr),
    .en(ctrl_q[CB_EN]), .enc_sel(ctrl_q[CB_ENC]), .prdy(ctrl_q[CB_PRDY]),
    .byte_vld(byte_vld), .codec_done(codec_done),
    .codec_start(codec_start), .pass_enc(pass_enc), .pass_fin(pass_fin)
  );

  necc_parity_file #(.NBYTES(PAR_BYTES), .IW(PIW)) u_par (
    .clk(clk), .rst_n(rst_n), .clr(sw_clr),
    .wr_en(par_wr), .wr_idx(par_idx), .wr_byte(bus_wdata),
    .cap_en(pass_fin && pass_enc), .cap_bus(codec_par_in),
    .par_bus(codec_par_out)
  );

  necc_report_file #(.N_REP(N_REP), .IDX_W(IDX_W), .MASK_W(MASK_W), .CNT_W(CNT_W), .RW(RW)) u_rep (
    .clk(clk), .rst_n(rst_n), .clr(sw_clr),
    .cap_en(pass_fin && !pass_enc), .cnt_in(codec_err_cnt),
    .rep_in(codec_reports), .rep_out(rep_bus)
  );

  assign codec_encode = pass_enc;
  assign codec_rs     = ctrl_q[CB_RS];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(0)) bus_rdata[4:0]    = ctrl_q;
    if (bus_addr == ADDR_W'(1)) bus_rdata[SW-1:0] = st_q;
    for (int k = 0; k < PAR_BYTES; k++)
      if (bus_addr == ADDR_W'(PAR_BASE + k)) bus_rdata[7:0] = codec_par_out[k*8 +: 8];
    for (int k = 0; k < N_REP; k++)
      if (bus_addr == ADDR_W'(REP_BASE + k)) begin
        bus_rdata[MASK_W-1:0]  = rep_bus[k*RW +: MASK_W];
        bus_rdata[16 +: IDX_W] = rep_bus[k*RW + MASK_W +: IDX_W];
      end
  end

  // R4
  enc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_fin && pass_enc) |=> st_q[SB_ENCF]);
  // R9
  hw_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_fin && !pass_enc) |=> st_q[SB_DECF]);
  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[SB_CNT +: CNT_W] <= CNT_W'(N_REP));
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && bus_wdata == '0 && !pass_fin) |=> (st_q == '0));
  // R11
  keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !bus_wdata[CB_RST] && !pass_fin) |=> ($stable(codec_par_out) && $stable(rep_bus)));
endmodule

// File: tb/nand_ecc_csr_tb.sv
`timescale 1ns/1ps
module nand_ecc_csr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        byte_vld = 1'b0;
  logic        codec_start, codec_encode, codec_rs;
  logic [71:0] codec_par_out;
  logic        codec_done = 1'b0;
  logic [71:0] codec_par_in = '0;
  logic [2:0]  codec_err_cnt = '0;
  logic        codec_uncor = 1'b0;
  logic [75:0] codec_reports = '0;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  nand_ecc_csr u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .byte_vld(byte_vld),
    .codec_start(codec_start), .codec_encode(codec_encode), .codec_rs(codec_rs),
    .codec_par_out(codec_par_out), .codec_done(codec_done),
    .codec_par_in(codec_par_in), .codec_err_cnt(codec_err_cnt),
    .codec_uncor(codec_uncor), .codec_reports(codec_reports)
  );

  task automatic chk(input string rq, input logic [127:0] got, input logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", rq, got, exp);
    end
  endtask

  // behavioural model of pass progress: 0 fill, 1 wait parity, 2 start, 3 busy, 4 done
  int   m_state = 0;
  int   m_bytes = 0;
  logic [4:0] m_ctrl = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_bytes = 0; m_ctrl = '0;
    end else begin
      if (bus_wr && bus_addr == 4'd0 && bus_wdata[1]) begin
        m_state = 0; m_bytes = 0;
      end else if (m_state == 0) begin
        if (m_ctrl[0] && byte_vld) begin
          m_bytes++;
          if (m_bytes == 512) m_state = m_ctrl[3] ? 2 : 1;
        end
      end else if (m_state == 1) begin
        if (m_ctrl[0] && m_ctrl[4]) m_state = 2;
      end else if (m_state == 2) begin
        m_state = 3;
      end else if (m_state == 3) begin
        if (codec_done) m_state = 4;
      end
      if (bus_wr && bus_addr == 4'd0) m_ctrl = bus_wdata[4:0] & 5'b11101;
    end
  end

  // R3 R5: start pulse compared against the model on every clock
  always @(negedge clk) if (rst_n) chk("R3/R5 start vs model", codec_start, (m_state == 2));

  task automatic wr(input int a, input int d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a[3:0]; bus_wdata = d[7:0];
    @(negedge clk); bus_wr = 1'b0;
  endtask
  task automatic rdchk(input string rq, input int a, input logic [31:0] exp);
    bus_addr = a[3:0]; #1; chk(rq, bus_rdata, exp);
  endtask
  task automatic bytes(input int n);
    repeat (n) begin @(negedge clk); byte_vld = 1'b1; end
    @(negedge clk); byte_vld = 1'b0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_done(input int cnt, input logic unc);
    @(negedge clk); codec_err_cnt = cnt[2:0]; codec_uncor = unc; codec_done = 1'b1;
    @(negedge clk); codec_done = 1'b0;
  endtask
  function automatic logic [18:0] rep(input int idx, input int msk);
    return {idx[9:0], msk[8:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [71:0] pexp;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rdchk("R1 ctrl", 0, 0);
    rdchk("R1 status", 1, 0);
    rdchk("R1 parity0", 2, 0);
    rdchk("R1 report0", 11, 0);
    chk("R1 start low", codec_start, 1'b0);

    // R2 control readback
    wr(0, 'h0F);
    rdchk("R2 ctrl readback, reset bit reads 0", 0, 'h0D);
    chk("R2 rs output", codec_rs, 1'b1);

    // R3 bytes ignored while disabled
    wr(0, 'h0A);
    bytes(600);
    chk("R3 no start when disabled", codec_start, 1'b0);

    // R3 encode pass start timing
    wr(0, 'h0F);
    bytes(511);
    chk("R3 no start at 511", codec_start, 1'b0);
    bytes(1);
    chk("R3 start after 512th", codec_start, 1'b1);
    chk("R2 encode direction", codec_encode, 1'b1);
    idle(1);
    chk("R3 single cycle", codec_start, 1'b0);
    bytes(20);

    // R4 parity capture
    for (int k = 0; k < 9; k++) codec_par_in[k*8 +: 8] = 8'h30 + 8'(k);
    pulse_done(0, 1'b0);
    for (int k = 0; k < 9; k++) rdchk("R4 parity byte", 2 + k, 32'h30 + k);
    rdchk("R4 encode flag", 1, 'h01);

    // R11 disable keeps results
    wr(0, 'h08);
    rdchk("R11 parity kept", 5, 'h33);
    rdchk("R11 status kept", 1, 'h01);

    // R8 clear all
    wr(1, 0);
    rdchk("R8 zero write clears", 1, 0);

    // R10 reset bit clears parity; decode pass
    wr(0, 'h07);
    rdchk("R10 parity cleared", 2, 0);
    pexp = '0;
    for (int k = 0; k < 9; k++) begin
      wr(2 + k, 'hA0 + k);
      pexp[k*8 +: 8] = 8'hA0 + 8'(k);
    end
    chk("R5 parity to codec", codec_par_out, pexp);
    bytes(512);
    idle(3);
    chk("R5 no start without parity-ready", codec_start, 1'b0);
    wr(0, 'h15);
    idle(1);
    chk("R5 start after parity-ready", codec_start, 1'b1);
    chk("R5 decode direction", codec_encode, 1'b0);
    idle(2);

    // R9 status write and decode finish in the same cycle; R6 R7
    codec_reports = {rep(9, 'h101), rep(5, 'h0FF), rep(600, 'h003), rep(37, 'h1A5)};
    @(negedge clk);
    codec_err_cnt = 3'd2; codec_uncor = 1'b0; codec_done = 1'b1;
    bus_wr = 1'b1; bus_addr = 4'd1; bus_wdata = 8'h00;
    @(negedge clk);
    codec_done = 1'b0; bus_wr = 1'b0;
    rdchk("R9 R6 decode status", 1, 'h26);
    rdchk("R7 report0", 11, (37 << 16) | 'h1A5);
    rdchk("R7 report1", 12, (600 << 16) | 'h003);
    rdchk("R7 report2 invalid", 13, 0);
    rdchk("R7 report3 invalid", 14, 0);

    // R12 stray done
    pulse_done(4, 1'b1);
    rdchk("R12 status unchanged", 1, 'h26);
    rdchk("R12 report2 unchanged", 13, 0);

    // R8 partial clear
    wr(1, 'h02);
    rdchk("R8 and-clear", 1, 'h02);

    // R10 reset with parity-ready preset; uncorrectable decode
    wr(0, 'h17);
    rdchk("R10 reports cleared", 11, 0);
    rdchk("R10 status untouched", 1, 'h02);
    bytes(512);
    idle(3);
    pulse_done(0, 1'b1);
    rdchk("R6 uncorrectable status", 1, 'h0E);
    rdchk("R7 count zero report", 11, 0);

    idle(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule